// File: doc/BRIEF.md
# Capture-Timer Auxiliary PWM Generator

This block is a memory-mapped timer whose capture registers are reused to produce one pulse-width-modulated output. A counter runs from zero up to a programmed period value and then returns to zero. The output is high while the count is below a programmed compare (duty) value. Software sets the active period and duty before starting the timer.

While the waveform runs, software retunes it through a second pair of staging registers. A staged value is moved into the active register only when the counter wraps, so every period is either wholly old or wholly new. Two separate control bits govern the block. One lets the counter advance. The other selects the PWM function. The two sync-select bits are stored so that software can read them back, but they do nothing.

Top module: `aux_pwm_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `pwm_out` is low.
- R2: Byte offsets select the registers: 0x08 active period, 0x0C active duty, 0x10 staged period, 0x14 staged duty, 0x2A control. Control is 16 bits wide, keeps only bits 15:0 of a write and reads back zero-extended. Any other offset reads zero, and a write to it changes nothing.
- R3: Control bit 4 is the run bit. While it is clear the counter holds its value. While it is set the counter steps by one per cycle and, on a cycle where it is at or above the active period, returns to zero. One period therefore lasts period+1 cycles.
- R4: Control bit 9 is the PWM select bit. `pwm_out` can be high only when bit 9 and bit 4 are both set. Clearing either bit and later setting it again resumes the waveform from the held count, with no reload of the active registers.
- R5: On each clock edge `pwm_out` takes the level computed from the register and counter values just before that edge. The level is high when the count is below the active duty, or when the active duty is at or above the active period. Otherwise it is low.
- R6: A write to a staged register leaves the active register and the waveform unchanged. At the next wrap, each staged value written since the previous wrap is copied into its active register. A staged register that was not written is not copied.
- R7: Control bits 7 and 6 are stored and read back, and have no effect on the counter or on `pwm_out`. This includes the value where both bits are set.
- R8: Active period 1 with duty 1 holds `pwm_out` high continuously. Period 2 with duty 1 gives one high cycle in every three. Duty 0 with a nonzero period holds it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` while `bus_sel` is high, zero otherwise |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench builds the block with the default parameters: DATA_W 32, CTRL_W 16 and ADDR_W 6. A six-bit offset is the smallest width that reaches the control register at 0x2A, so the unmapped offsets and the zero-extended control read-back are both exercised. Programmed periods stay between 1 and 9 cycles. This brings many wraps into a short run, so staged writes land at several different counter phases, including the wrap cycle itself. It also covers the one-cycle minimum period and the duty-above-period corner. The values near the full 32-bit counter range are left out of reach.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;

  // Byte offsets of the register map
  localparam int OFF_PER_ACT  = 'h08;
  localparam int OFF_DUTY_ACT = 'h0C;
  localparam int OFF_PER_SH   = 'h10;
  localparam int OFF_DUTY_SH  = 'h14;
  localparam int OFF_CTRL     = 'h2A;

  // Control register bit positions
  localparam int BIT_RUN     = 4;
  localparam int BIT_SYNC_LO = 6;
  localparam int BIT_SYNC_HI = 7;
  localparam int BIT_MODE    = 9;

  // Channel index inside the active/staged register pairs
  localparam int CH_PER  = 0;
  localparam int CH_DUTY = 1;
  localparam int N_CH    = 2;

  typedef struct packed {
    logic ctrl;
    logic duty_sh;
    logic per_sh;
    logic duty_act;
    logic per_act;
  } wr_strobe_t;

endpackage

// File: rtl/aux_pwm_regs.sv
module aux_pwm_regs
  import aux_pwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wrap_i,
  output logic [DATA_W-1:0] per_o,
  output logic [DATA_W-1:0] duty_o,
  output logic              run_o,
  output logic              mode_o
);

  function automatic wr_strobe_t decode_wr(logic sel, logic wr, logic [ADDR_W-1:0] a);
    wr_strobe_t s;
    s = '0;
    if (sel && wr) begin
      case (a)
        ADDR_W'(OFF_PER_ACT):  s.per_act  = 1'b1;
        ADDR_W'(OFF_DUTY_ACT): s.duty_act = 1'b1;
        ADDR_W'(OFF_PER_SH):   s.per_sh   = 1'b1;
        ADDR_W'(OFF_DUTY_SH):  s.duty_sh  = 1'b1;
        ADDR_W'(OFF_CTRL):     s.ctrl     = 1'b1;
        default:               s          = '0;
      endcase
    end
    return s;
  endfunction

  wr_strobe_t st;
  logic [N_CH-1:0]             wr_act, wr_sh, pend_q, load_act;
  logic [N_CH-1:0][DATA_W-1:0] act_q, sh_q;
  logic [CTRL_W-1:0]           ctrl_q;

  assign st     = decode_wr(bus_sel, bus_wr, bus_addr);
  assign wr_act = {st.duty_act, st.per_act};
  assign wr_sh  = {st.duty_sh, st.per_sh};

  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_ch
      assign load_act[g] = wrap_i && pend_q[g];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          act_q[g]  <= '0;
          sh_q[g]   <= '0;
          pend_q[g] <= 1'b0;
        end else begin
          if (load_act[g])     act_q[g] <= sh_q[g];
          else if (wr_act[g])  act_q[g] <= bus_wdata;
          if (wr_sh[g])        sh_q[g]  <= bus_wdata;
          if (wr_sh[g])        pend_q[g] <= 1'b1;
          else if (wrap_i)     pend_q[g] <= 1'b0;
        end
      end

      AST_STAGED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && pend_q[g]) |=> act_q[g] == $past(sh_q[g])); // R6
      AST_STAGED_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sh[g] && !wr_act[g] && !wrap_i) |=> $stable(act_q[g])); // R6
      AST_UNWRITTEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !pend_q[g] && !wr_act[g]) |=> $stable(act_q[g])); // R6
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (st.ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        ADDR_W'(OFF_PER_ACT):  bus_rdata = act_q[CH_PER];
        ADDR_W'(OFF_DUTY_ACT): bus_rdata = act_q[CH_DUTY];
        ADDR_W'(OFF_PER_SH):   bus_rdata = sh_q[CH_PER];
        ADDR_W'(OFF_DUTY_SH):  bus_rdata = sh_q[CH_DUTY];
        ADDR_W'(OFF_CTRL):     bus_rdata = DATA_W'(ctrl_q);
        default:               bus_rdata = '0;
      endcase
    end
  end

  assign per_o  = act_q[CH_PER];
  assign duty_o = act_q[CH_DUTY];
  assign run_o  = ctrl_q[BIT_RUN];
  assign mode_o = ctrl_q[BIT_MODE];

  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !st.ctrl |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/aux_pwm_counter.sv
module aux_pwm_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [DATA_W-1:0] per_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              wrap_o
);

  function automatic logic at_end(logic [DATA_W-1:0] c, logic [DATA_W-1:0] p);
    return c >= p;
  endfunction

  function automatic logic [DATA_W-1:0] step(logic [DATA_W-1:0] c, logic w);
    return w ? '0 : c + 1'b1;
  endfunction

  logic [DATA_W-1:0] cnt_q;

  assign wrap_o = run_i && at_end(cnt_q, per_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (run_i) cnt_q <= step(cnt_q, wrap_o);
  end

  assign cnt_o = cnt_q;

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == '0); // R3
  AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !wrap_o) |=> cnt_q != '0); // R3

endmodule

// File: rtl/aux_pwm_wave.sv
module aux_pwm_wave #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [DATA_W-1:0] duty_i,
  input  logic [DATA_W-1:0] per_i,
  output logic              pwm_o
);

  function automatic logic level(logic [DATA_W-1:0] c, logic [DATA_W-1:0] d,
                                 logic [DATA_W-1:0] p);
    return (d >= p) || (c < d);
  endfunction

  logic active, pwm_q;

  assign active = run_i && mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= active && level(cnt_i, duty_i, per_i);
  end

  assign pwm_o = pwm_q;

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pwm_o); // R4
  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && duty_i >= per_i) |=> pwm_o); // R5
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0 && per_i != '0) |=> !pwm_o); // R8

endmodule

// File: rtl/aux_pwm_timer.sv
module aux_pwm_timer
  import aux_pwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);

  localparam int MIN_CTRL_W = BIT_MODE + 1;

  logic [DATA_W-1:0] per_act, duty_act, cnt;
  logic              run, mode, wrap;

  initial begin
    if (CTRL_W < MIN_CTRL_W) $error("CTRL_W too narrow for the mode bit");
    if ((1 << ADDR_W) <= OFF_CTRL) $error("ADDR_W cannot reach the control offset");
  end

  aux_pwm_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wrap_i(wrap), .per_o(per_act), .duty_o(duty_act), .run_o(run), .mode_o(mode)
  );

  aux_pwm_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .per_i(per_act),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  aux_pwm_wave #(.DATA_W(DATA_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .run_i(run), .mode_i(mode), .cnt_i(cnt),
    .duty_i(duty_act), .per_i(per_act), .pwm_o(pwm_out)
  );

  AST_WRAP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> run); // R3

endmodule

// File: tb/sim_aux_pwm_timer.sv
module sim_aux_pwm_timer;

  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          pwm_out;

  aux_pwm_timer #(.DATA_W(DW), .CTRL_W(16), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R1";
  bit    sbq[$];

  // Bench model of the register file and counter, built from the requirements
  logic [DW-1:0] m_per, m_duty, m_sper, m_sduty, m_cnt;
  logic          m_pp, m_pd;
  logic [15:0]   m_ctrl;

  always @(posedge clk) begin
    bit e, run, mode, wrap, wa;
    if (!rst_n) begin
      m_per = 0; m_duty = 0; m_sper = 0; m_sduty = 0; m_cnt = 0;
      m_pp = 0; m_pd = 0; m_ctrl = 0; e = 0;
    end else begin
      run  = m_ctrl[4];
      mode = m_ctrl[9];
      e    = run && mode && ((m_duty >= m_per) || (m_cnt < m_duty));
      wrap = run && (m_cnt >= m_per);
      wa   = bus_sel && bus_wr;
      if (run) m_cnt = wrap ? 0 : m_cnt + 1;
      if (wrap && m_pp) m_per = m_sper;
      else if (wa && bus_addr == 6'h08) m_per = bus_wdata;
      if (wrap && m_pd) m_duty = m_sduty;
      else if (wa && bus_addr == 6'h0C) m_duty = bus_wdata;
      if (wa && bus_addr == 6'h10) begin m_sper = bus_wdata; m_pp = 1; end
      else if (wrap) m_pp = 0;
      if (wa && bus_addr == 6'h14) begin m_sduty = bus_wdata; m_pd = 1; end
      else if (wrap) m_pd = 0;
      if (wa && bus_addr == 6'h2A) m_ctrl = bus_wdata[15:0];
    end
    sbq.push_back(e);
  end

  // Monitor: compare the registered output against the expected stream
  always @(negedge clk) begin
    bit e;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      n_vec++;
      if (pwm_out !== e) begin
        n_bad++;
        $display("FAIL %s pwm_out got %0b exp %0b at %0t", cur_req, pwm_out, e, $time);
      end
    end
  end

  function automatic logic [DW-1:0] model_read(logic [AW-1:0] a);
    case (a)
      6'h08:   return m_per;
      6'h0C:   return m_duty;
      6'h10:   return m_sper;
      6'h14:   return m_sduty;
      6'h2A:   return {16'h0, m_ctrl};
      default: return '0;
    endcase
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_check(input logic [AW-1:0] a);
    logic [DW-1:0] exp;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    exp = model_read(a);
    n_vec++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read 0x%0h got 0x%0h exp 0x%0h", cur_req, a, bus_rdata, exp);
    end
    bus_sel = 0;
  endtask

  task automatic check_all();
    rd_check(6'h08); rd_check(6'h0C); rd_check(6'h10);
    rd_check(6'h14); rd_check(6'h2A); rd_check(6'h04);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    cur_req = "R1";             // all registers zero, output low, counter stopped
    check_all();
    idle(6);

    cur_req = "R2";             // map, unmapped offset, 16-bit control
    wr(6'h08, 5); wr(6'h0C, 2);
    wr(6'h04, 32'hDEAD_BEEF);
    wr(6'h2A, 32'h0001_0000);
    check_all();

    cur_req = "R3";             // run + PWM select, then hold with run clear
    wr(6'h2A, 32'h0210); idle(20);
    wr(6'h2A, 32'h0200); idle(8);
    check_all();

    cur_req = "R4";             // run without PWM select, then resume
    wr(6'h2A, 32'h0010); idle(9);
    wr(6'h2A, 32'h0000); idle(3);
    wr(6'h2A, 32'h0210); idle(14);
    check_all();

    cur_req = "R6";             // staged writes take effect only at wrap
    wr(6'h10, 9); rd_check(6'h08);
    wr(6'h14, 4); rd_check(6'h0C);
    idle(25); check_all();
    wr(6'h14, 6); idle(30); check_all();

    cur_req = "R5";             // duty at/above period, duty below period
    wr(6'h14, 12); idle(24);
    wr(6'h14, 9);  idle(24);
    wr(6'h14, 3);  idle(24);
    check_all();

    cur_req = "R7";             // sync bits stored, no effect
    wr(6'h2A, 32'h02D0); idle(25);
    wr(6'h2A, 32'h0250); idle(12);
    check_all();

    cur_req = "R8";             // minimum settings
    wr(6'h10, 1); wr(6'h14, 1); idle(14); check_all();
    wr(6'h10, 2); idle(15); check_all();
    wr(6'h14, 0); idle(12); check_all();
    wr(6'h08, 2); wr(6'h0C, 0); idle(8);

    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule